// File: doc/BRIEF.md
# Broadcast Storm Rate Limiter

This block guards one switch ingress port against floods of broadcast traffic. For every arriving frame it receives a start strobe, a flag saying the destination address is all ones, and the frame length in bytes. It meters broadcast data in units of 64-byte blocks. A frame of L bytes costs ceil(L/64) blocks. The block count is checked against a programmable budget inside a fixed measurement window.

The window length depends on link speed. At 100 Mbps it corresponds to 67 ms and at 10 Mbps to 500 ms, and both lengths are given as clock-cycle parameters so that short windows can be used in simulation. The budget arrives as two fields: a low byte and a small high field. A broadcast frame that would take the window's count above the budget is marked for dropping. A dropped frame consumes nothing. Other frames pass untouched and are not metered. Metering is active only while both the global enable and the per-port enable are set.

One cycle after each frame-start strobe the block presents a single-cycle decision.

Top module: `bcast_storm_limiter`

## Requirements
- R1: After reset, and in every cycle not directly following a `frameStart`, `decisionValid` and `dropFrame` are 0; in the cycle after each `frameStart`, `decisionValid` is 1 for exactly one cycle.
- R2: A metered frame costs ceil(`frameLen`/64) blocks: 1..64 bytes cost 1 block, 65..128 bytes cost 2 blocks, and so on.
- R3: A metered frame is dropped when the blocks already used in the window plus its own cost exceed the budget. Reaching the budget exactly is allowed. A dropped frame adds nothing to the used count.
- R4: A frame with `frameIsBcast` = 0 is always forwarded and adds nothing to the used count.
- R5: When either `globalEn` or `portEn` is 0, broadcast frames are forwarded and not counted, and the budget stays unused for later metered frames.
- R6: The budget is {`budgetHi`, `budgetLo`}, with `budgetLo` as bits 7:0 and `budgetHi` above them.
- R7: With `linkFast` = 1, the used count clears every `WIN_FAST_CYCLES` cycles. The boundary falls at the `WIN_FAST_CYCLES`-th clock edge after the window starts.
- R8: With `linkFast` = 0, the window is `WIN_SLOW_CYCLES` cycles long, with the same boundary rule.
- R9: Any change of `linkFast` restarts the window timer at that clock edge and clears the used count.
- R10: A frame whose evaluation edge coincides with a window boundary or restart is measured against the fresh, empty window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle strobe, a frame arrives |
| frameIsBcast | input | 1 | Destination address is all ones |
| frameLen | input | LEN_W | Frame length in bytes |
| linkFast | input | 1 | 1 = 100 Mbps window, 0 = 10 Mbps window |
| globalEn | input | 1 | Switch-wide storm protection enable |
| portEn | input | 1 | Enable for this port |
| budgetLo | input | 8 | Budget bits 7:0 |
| budgetHi | input | BUDGET_W-8 | Budget upper bits |
| decisionValid | output | 1 | Decision for the last frame is present |
| dropFrame | output | 1 | 1 = drop the frame, 0 = forward it |

## Verification
Several properties are checked on every cycle:
- the decision timing;
- that a drop only follows a metered broadcast frame;
- that a drop leaves the used count unchanged;
- that the count never grows past the budget;
- that the gap between window restarts never exceeds the current window length.

Other behaviour can only be shown by the bench's scenarios. This covers the exact block cost of particular lengths, the split budget fields, and the enables preserving budget. It also covers the edge-exact placement of the fast and slow window boundaries and the restart on a speed change.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  typedef struct packed {
    logic newWindow;   // window boundary or speed-change restart this edge
    logic meter;       // current frame is a metered broadcast frame
  } bslStrobe_t;
endpackage

// File: rtl/bsl_ctrl.sv
module bsl_ctrl
  import bsl_pkg::*;
#(
  parameter int unsigned WIN_FAST_CYCLES = 8375000,
  parameter int unsigned WIN_SLOW_CYCLES = 62500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       frameIsBcast,
  input  logic       linkFast,
  input  logic       globalEn,
  input  logic       portEn,
  output bslStrobe_t strobe
);
  localparam int unsigned WIN_MAX = (WIN_SLOW_CYCLES > WIN_FAST_CYCLES) ? WIN_SLOW_CYCLES : WIN_FAST_CYCLES;
  localparam int unsigned TMR_W   = $clog2(WIN_MAX + 1);
  localparam logic [TMR_W-1:0] LAST_FAST = TMR_W'(WIN_FAST_CYCLES - 1);
  localparam logic [TMR_W-1:0] LAST_SLOW = TMR_W'(WIN_SLOW_CYCLES - 1);

  logic [TMR_W-1:0] winTimer;
  logic [TMR_W-1:0] winLast;
  logic             prevFast;
  logic             speedChange;
  logic             windowEnd;

  always_comb begin
    winLast          = linkFast ? LAST_FAST : LAST_SLOW;
    speedChange      = linkFast != prevFast;
    windowEnd        = winTimer >= winLast;
    strobe.newWindow = windowEnd | speedChange;
    strobe.meter     = frameStart & frameIsBcast & globalEn & portEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winTimer <= '0;
      prevFast <= linkFast;
    end else begin
      prevFast <= linkFast;
      winTimer <= strobe.newWindow ? '0 : winTimer + 1'b1;
    end
  end
endmodule

// File: rtl/bsl_datapath.sv
module bsl_datapath
  import bsl_pkg::*;
#(
  parameter int unsigned LEN_W    = 11,
  parameter int unsigned BUDGET_W = 11,
  localparam int unsigned BLK_W   = LEN_W - 5,
  localparam int unsigned CNT_W   = ((BUDGET_W > BLK_W) ? BUDGET_W : BLK_W) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  bslStrobe_t          strobe,
  input  logic                frameStart,
  input  logic [LEN_W-1:0]    frameLen,
  input  logic [BUDGET_W-1:0] budget,
  output logic                decisionValid,
  output logic                dropFrame,
  output logic [CNT_W-1:0]    usedBlocks
);
  logic [LEN_W:0]   lenRound;
  logic [BLK_W-1:0] frameBlocks;
  logic [CNT_W-1:0] baseCount;
  logic [CNT_W-1:0] sumCount;
  logic             overBudget;

  always_comb begin
    lenRound    = {1'b0, frameLen} + (LEN_W+1)'(63);
    frameBlocks = lenRound[LEN_W:6];
    baseCount   = strobe.newWindow ? '0 : usedBlocks;
    sumCount    = baseCount + CNT_W'(frameBlocks);
    overBudget  = sumCount > CNT_W'(budget);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      usedBlocks    <= '0;
      decisionValid <= 1'b0;
      dropFrame     <= 1'b0;
    end else begin
      decisionValid <= frameStart;
      dropFrame     <= strobe.meter & overBudget;
      usedBlocks    <= (strobe.meter && !overBudget) ? sumCount : baseCount;
    end
  end
endmodule

// File: rtl/bcast_storm_limiter.sv
module bcast_storm_limiter
  import bsl_pkg::*;
#(
  parameter int unsigned LEN_W           = 11,
  parameter int unsigned BUDGET_W        = 11,
  parameter int unsigned WIN_FAST_CYCLES = 8375000,
  parameter int unsigned WIN_SLOW_CYCLES = 62500000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameStart,
  input  logic                frameIsBcast,
  input  logic [LEN_W-1:0]    frameLen,
  input  logic                linkFast,
  input  logic                globalEn,
  input  logic                portEn,
  input  logic [7:0]          budgetLo,
  input  logic [BUDGET_W-9:0] budgetHi,
  output logic                decisionValid,
  output logic                dropFrame
);
  localparam int unsigned BLK_W = LEN_W - 5;
  localparam int unsigned CNT_W = ((BUDGET_W > BLK_W) ? BUDGET_W : BLK_W) + 1;

  bslStrobe_t          strobe;
  logic [BUDGET_W-1:0] budget;
  logic [CNT_W-1:0]    usedBlocks;

  assign budget = {budgetHi, budgetLo};

  bsl_ctrl #(
    .WIN_FAST_CYCLES(WIN_FAST_CYCLES),
    .WIN_SLOW_CYCLES(WIN_SLOW_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameIsBcast(frameIsBcast),
    .linkFast(linkFast), .globalEn(globalEn), .portEn(portEn), .strobe(strobe)
  );

  bsl_datapath #(
    .LEN_W(LEN_W),
    .BUDGET_W(BUDGET_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .frameStart(frameStart),
    .frameLen(frameLen), .budget(budget), .decisionValid(decisionValid),
    .dropFrame(dropFrame), .usedBlocks(usedBlocks)
  );
endmodule

// File: rtl/bsl_checker.sv
module bsl_checker #(
  parameter int unsigned BUDGET_W        = 11,
  parameter int unsigned CNT_W           = 12,
  parameter int unsigned WIN_FAST_CYCLES = 8375000,
  parameter int unsigned WIN_SLOW_CYCLES = 62500000
) (
  input logic                clk,
  input logic                rstN,
  input logic                frameStart,
  input logic                frameIsBcast,
  input logic                globalEn,
  input logic                portEn,
  input logic                linkFast,
  input logic [BUDGET_W-1:0] budget,
  input logic                newWindow,
  input logic [CNT_W-1:0]    usedBlocks,
  input logic                decisionValid,
  input logic                dropFrame
);
  logic [31:0] gapCount;
  always_ff @(posedge clk) begin
    if (!rstN)          gapCount <= '0;
    else if (newWindow) gapCount <= '0;
    else                gapCount <= gapCount + 1;
  end

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rstN) frameStart |=> decisionValid); // R1
  AST_VALID_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (!rstN) !frameStart |=> !decisionValid && !dropFrame); // R1
  AST_DROP_NEEDS_METER: assert property (@(posedge clk) disable iff (!rstN) dropFrame |-> $past(frameIsBcast && globalEn && portEn)); // R4
  AST_DROP_NO_CONSUME: assert property (@(posedge clk) disable iff (!rstN) dropFrame |-> usedBlocks == ($past(newWindow) ? '0 : $past(usedBlocks))); // R3
  AST_USED_LE_BUDGET: assert property (@(posedge clk) disable iff (!rstN) (usedBlocks > $past(usedBlocks)) |-> usedBlocks <= CNT_W'($past(budget))); // R3
  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rstN) gapCount < (linkFast ? WIN_FAST_CYCLES : WIN_SLOW_CYCLES)); // R7
endmodule

bind bcast_storm_limiter bsl_checker #(
  .BUDGET_W(BUDGET_W),
  .CNT_W(CNT_W),
  .WIN_FAST_CYCLES(WIN_FAST_CYCLES),
  .WIN_SLOW_CYCLES(WIN_SLOW_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameIsBcast(frameIsBcast),
  .globalEn(globalEn), .portEn(portEn), .linkFast(linkFast), .budget(budget),
  .newWindow(strobe.newWindow), .usedBlocks(usedBlocks),
  .decisionValid(decisionValid), .dropFrame(dropFrame)
);

// File: tb/bcast_storm_limiter_bench.sv
`timescale 1ns/1ps
module bcast_storm_limiter_bench;
  localparam int unsigned LEN_W = 11;
  localparam int unsigned BUDGET_W = 11;
  localparam int unsigned FAST = 200;
  localparam int unsigned SLOW = 600;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0;
  logic frameIsBcast = 1'b0;
  logic [LEN_W-1:0] frameLen = '0;
  logic linkFast = 1'b1;
  logic globalEn = 1'b1;
  logic portEn = 1'b1;
  logic [7:0] budgetLo = 8'd0;
  logic [BUDGET_W-9:0] budgetHi = '0;
  logic decisionValid;
  logic dropFrame;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int restartCyc = 0;

  always #4 clk = ~clk;
  always_ff @(posedge clk) cyc <= cyc + 1;

  bcast_storm_limiter #(
    .LEN_W(LEN_W), .BUDGET_W(BUDGET_W),
    .WIN_FAST_CYCLES(FAST), .WIN_SLOW_CYCLES(SLOW)
  ) u_bcast_storm_limiter (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameIsBcast(frameIsBcast),
    .frameLen(frameLen), .linkFast(linkFast), .globalEn(globalEn), .portEn(portEn),
    .budgetLo(budgetLo), .budgetHi(budgetHi),
    .decisionValid(decisionValid), .dropFrame(dropFrame)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic setBudget(input int b);
    {budgetHi, budgetLo} = BUDGET_W'(b);
  endtask

  // start a fresh window at a known edge by toggling the speed bit twice
  task automatic restartWindow(input bit fast);
    linkFast = ~fast;
    @(posedge clk); @(negedge clk);
    linkFast = fast;
    @(posedge clk); @(negedge clk);
    restartCyc = cyc;
  endtask

  task automatic idleUntil(input int n);
    while (cyc - restartCyc < n) @(negedge clk);
  endtask

  task automatic sendFrame(input bit bcast, input int len, input bit expDrop, input string req);
    frameStart = 1'b1;
    frameIsBcast = bcast;
    frameLen = LEN_W'(len);
    @(posedge clk); @(negedge clk);
    frameStart = 1'b0;
    check(decisionValid === 1'b1, "R1", int'(decisionValid), 1);
    check(dropFrame === expDrop, req, int'(dropFrame), int'(expDrop));
  endtask

  task automatic testReset();
    check(decisionValid === 1'b0, "R1 reset", int'(decisionValid), 0);
    check(dropFrame === 1'b0, "R1 reset", int'(dropFrame), 0);
    @(negedge clk);
    check(decisionValid === 1'b0, "R1 idle", int'(decisionValid), 0);
  endtask

  task automatic testBasic();
    setBudget(5);
    restartWindow(1'b1);
    for (int i = 0; i < 5; i++) sendFrame(1'b1, 64, 1'b0, "R3 within budget");
    sendFrame(1'b1, 64, 1'b1, "R3 over budget");
    sendFrame(1'b0, 1518, 1'b0, "R4 non-broadcast passes");
    sendFrame(1'b1, 64, 1'b1, "R4 non-broadcast not counted");
    @(negedge clk);
    check(decisionValid === 1'b0, "R1 single cycle", int'(decisionValid), 0);
  endtask

  task automatic testCeiling();
    setBudget(3);
    restartWindow(1'b1);
    sendFrame(1'b1, 65, 1'b0, "R2 65 bytes is 2 blocks");
    sendFrame(1'b1, 128, 1'b1, "R2 128 bytes is 2 blocks");
    sendFrame(1'b1, 64, 1'b0, "R3 exact budget, drop consumed nothing");
    sendFrame(1'b1, 1, 1'b1, "R2 1 byte is 1 block");
  endtask

  task automatic testEnables();
    setBudget(1);
    restartWindow(1'b1);
    globalEn = 1'b0;
    for (int i = 0; i < 3; i++) sendFrame(1'b1, 64, 1'b0, "R5 global off");
    globalEn = 1'b1; portEn = 1'b0;
    for (int i = 0; i < 2; i++) sendFrame(1'b1, 64, 1'b0, "R5 port off");
    portEn = 1'b1;
    sendFrame(1'b1, 64, 1'b0, "R5 budget untouched while off");
    sendFrame(1'b1, 64, 1'b1, "R5 metering resumes");
  endtask

  task automatic testHighBudget();
    setBudget(256);   // budgetHi=1, budgetLo=0
    restartWindow(1'b1);
    for (int i = 0; i < 10; i++) sendFrame(1'b1, 1518, 1'b0, "R6 upper field counts");
    sendFrame(1'b1, 1518, 1'b1, "R6 264 over 256");
    sendFrame(1'b1, 1024, 1'b0, "R6 reaches 256 exactly");
    sendFrame(1'b1, 1, 1'b1, "R6 full");
  endtask

  task automatic testFastWindow();
    setBudget(2);
    restartWindow(1'b1);
    sendFrame(1'b1, 64, 1'b0, "R7 fill");
    sendFrame(1'b1, 64, 1'b0, "R7 fill");
    sendFrame(1'b1, 64, 1'b1, "R7 full");
    idleUntil(FAST - 2);
    sendFrame(1'b1, 64, 1'b1, "R7 edge before boundary");
    sendFrame(1'b1, 64, 1'b0, "R10 frame on boundary edge");
    sendFrame(1'b1, 64, 1'b0, "R7 new window");
    sendFrame(1'b1, 64, 1'b1, "R7 new window full");
  endtask

  task automatic testSlowWindow();
    setBudget(1);
    restartWindow(1'b0);
    sendFrame(1'b1, 64, 1'b0, "R8 fill");
    sendFrame(1'b1, 64, 1'b1, "R8 full");
    idleUntil(FAST + 50);
    sendFrame(1'b1, 64, 1'b1, "R8 no clear at fast length");
    idleUntil(SLOW - 2);
    sendFrame(1'b1, 64, 1'b1, "R8 edge before boundary");
    sendFrame(1'b1, 64, 1'b0, "R8 cleared at slow boundary");
  endtask

  task automatic testSpeedChange();
    setBudget(1);
    restartWindow(1'b1);
    sendFrame(1'b1, 64, 1'b0, "R9 fill");
    sendFrame(1'b1, 64, 1'b1, "R9 full");
    idleUntil(100);
    linkFast = 1'b0;
    sendFrame(1'b1, 64, 1'b0, "R9 speed change clears, R10 same edge");
    sendFrame(1'b1, 64, 1'b1, "R9 new window full");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testBasic();
    testCeiling();
    testEnables();
    testHighBudget();
    testFastWindow();
    testSlowWindow();
    testSpeedChange();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule